// File: doc/BRIEF.md
# Receive Payload Bit FIFO with Transparent Serial Output

This block sits behind a receiver's line decoder. It takes decoded bits, each marked by a one-cycle valid pulse, plus a tick that fires sixteen times per bit period. It also takes three one-cycle events: frame sync found, end of message and start of a receive cycle. Only the payload that follows a frame sync is kept. Wake-up, run-in and sync-word bits never reach either output. Payload bits are stored in a 32-entry single-bit FIFO. A host drains that FIFO one bit at a time.

When transparent mode is enabled, every payload bit the block accepts is also driven onto one of two selectable serial data pins. A strobe marks each bit: it goes high one tick after the bit appears and stays high for one tick. The FIFO can lock itself at end of message, which stops both paths. It can also be cleared at cycle start, at frame sync, or by the host. Any of these clears also releases the lock and the overflow flag.

Top module: `rx_bitfifo_xparent`

## Requirements
- R1: A bit with `bit_valid` high is accepted only while a frame is open. A frame opens in the cycle after a `frame_sync` pulse and closes after an `eom` or `cycle_start` pulse. Bits outside a frame change neither the FIFO level nor the data pins.
- R2: While `locked` is 1, no bit is accepted. The FIFO level does not rise and the data pins and strobe keep their state.
- R3: With `cfg_lock_eom`=1, an `eom` pulse sets `locked` in the next cycle. With `cfg_lock_eom`=0, `locked` stays 0.
- R4: The strobe is active high. It is 0 in the cycle after a bit is accepted. It rises after the first `bit_tick` that follows, and falls after the next `bit_tick`.
- R5: With `cfg_xpar_en`=1, `cfg_pin_sel`=0 drives the last accepted bit on `xd_pin_a` and holds `xd_pin_b` at 0. `cfg_pin_sel`=1 swaps the two pins. With `cfg_xpar_en`=0, both pins and the strobe are 0.
- R6: A `cycle_start` pulse with `cfg_init_cycle`=1 empties the FIFO and clears `overflow` and `locked`.
- R7: A `frame_sync` pulse with `cfg_init_frame`=1 empties the FIFO and clears `overflow` and `locked`. With `cfg_init_frame`=0, the stored bits are kept.
- R8: A `host_clear` pulse empties the FIFO and clears `overflow` and `locked`. A bit arriving in the same cycle as any clear is dropped.
- R9: The FIFO returns bits oldest first. `rd_data` shows the oldest stored bit, and `rd_en` removes it when `empty` is 0. `level` counts the stored bits. `empty` is high at level 0 and `full` is high at level 32.
- R10: An accepted bit that arrives while the FIFO is full, with no read in the same cycle, is not stored. It sets `overflow`, which stays high until a clear. The bit still appears on the transparent output.
- R11: The selected data pin holds the last accepted bit until the next accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | Enable pulse, 16 per bit period |
| bit_valid | input | 1 | Decoded bit present this cycle |
| bit_data | input | 1 | Decoded bit value |
| frame_sync | input | 1 | Frame synchronisation found |
| eom | input | 1 | End of message |
| cycle_start | input | 1 | Start of receive cycle |
| cfg_init_cycle | input | 1 | Clear FIFO at cycle start |
| cfg_init_frame | input | 1 | Clear FIFO at frame sync |
| cfg_lock_eom | input | 1 | Lock FIFO at end of message |
| cfg_xpar_en | input | 1 | Transparent output enable |
| cfg_pin_sel | input | 1 | Data pin select (0: A, 1: B) |
| host_clear | input | 1 | Host clear of FIFO, lock and overflow |
| rd_en | input | 1 | Pop oldest bit |
| rd_data | output | 1 | Oldest stored bit |
| level | output | 6 | Stored bit count |
| empty | output | 1 | FIFO empty |
| full | output | 1 | FIFO full |
| overflow | output | 1 | Sticky write-drop flag |
| locked | output | 1 | FIFO locked |
| xd_pin_a | output | 1 | Transparent data, pin A |
| xd_pin_b | output | 1 | Transparent data, pin B |
| xd_strobe | output | 1 | Transparent data strobe |

## Verification
The assertions check, on every cycle:
- that the lock sets after an enabled end of message and never sets when that option is off;
- that the level moves by at most one step unless a clear occurs, and never rises while the FIFO is locked;
- that overflow stays set until a clear;
- that the strobe only rises right after a tick;
- that at most one data pin is high.

Other behaviour only the bench scenarios can show:
- that bit order is kept end to end;
- that bits before a sync are dropped;
- that each clear source empties the FIFO;
- the exact tick timing of the strobe;
- that the data pin holds its value between bits.

// File: rtl/rxf_pkg.sv
// Shared parameters and types for the receive payload FIFO block.
package rxf_pkg;
    localparam int unsigned RXF_DEPTH = 32;
    localparam int unsigned RXF_PINS  = 2;

    // Strobe sequencer states, advanced only on the bit tick.
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WAIT = 2'd1,
        XS_HIGH = 2'd2
    } xs_state_t;
endpackage

// File: rtl/rxf_frame_ctrl.sv
// Frame gate and lock control.
// Tracks whether a frame is open, holds the end-of-message lock and
// combines the clear sources. Assumes all event inputs are one-cycle pulses.
module rxf_frame_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic frame_sync,
    input  logic eom,
    input  logic cycle_start,
    input  logic cfg_init_cycle,
    input  logic cfg_init_frame,
    input  logic cfg_lock_eom,
    input  logic host_clear,
    output logic clear_any,
    output logic accept,
    output logic locked
);
    logic in_frame_q;
    logic locked_q;

    // Any enabled clear source empties the store and releases the lock.
    always_comb begin
        clear_any = host_clear
                  | (cycle_start & cfg_init_cycle)
                  | (frame_sync & cfg_init_frame);
    end

    // A bit passes only inside an open, unlocked frame with no clear.
    always_comb begin
        accept = bit_valid & in_frame_q & ~locked_q & ~clear_any;
    end

    // Frame window: opened by sync, closed by end of message or new cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
        end else if (frame_sync) begin
            in_frame_q <= 1'b1;
        end else if (eom || cycle_start) begin
            in_frame_q <= 1'b0;
        end
    end

    // Lock register: clears take priority over the end-of-message set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (clear_any) begin
            locked_q <= 1'b0;
        end else if (eom && cfg_lock_eom) begin
            locked_q <= 1'b1;
        end
    end

    assign locked = locked_q;
endmodule

// File: rtl/rxf_bit_store.sv
// Single-bit-wide circular FIFO with a level count and sticky overflow.
// A read and a write may occur in one cycle, even when the store is full.
// A clear empties the store and drops any write in the same cycle.
module rxf_bit_store #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_req,
    output logic          rd_bit,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          overflow
);
    localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

    logic [DEPTH-1:0] mem_q;
    logic [PW-1:0]    wr_ptr_q;
    logic [PW-1:0]    rd_ptr_q;
    logic [LW-1:0]    count_q;
    logic             ovf_q;
    logic             do_rd;
    logic             do_wr;
    logic             drop;

    // Work out which of read, write and drop happen this cycle.
    always_comb begin
        do_rd = rd_req & (count_q != '0) & ~clear;
        do_wr = wr_en & ~clear & ((count_q != LVL_MAX) | do_rd);
        drop  = wr_en & ~clear & (count_q == LVL_MAX) & ~do_rd;
    end

    // One storage flop per slot, loaded when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= 1'b0;
            end else if (do_wr && (wr_ptr_q == PW'(i))) begin
                mem_q[i] <= wr_bit;
            end
        end
    end

    // Pointer, level and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (do_wr) begin
                wr_ptr_q <= (wr_ptr_q == PTR_MAX) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_rd) begin
                rd_ptr_q <= (rd_ptr_q == PTR_MAX) ? '0 : rd_ptr_q + 1'b1;
            end
            if (do_wr && !do_rd) begin
                count_q <= count_q + 1'b1;
            end else if (do_rd && !do_wr) begin
                count_q <= count_q - 1'b1;
            end
            if (drop) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // Status and head-of-queue outputs.
    always_comb begin
        rd_bit   = mem_q[rd_ptr_q];
        level    = count_q;
        empty    = (count_q == '0);
        full     = (count_q == LVL_MAX);
        overflow = ovf_q;
    end
endmodule

// File: rtl/rxf_xpar_out.sv
// Transparent serial output.
// Holds the last accepted bit, routes it to the selected data pin and
// runs a strobe that goes high one tick after the bit and lasts one tick.
// Assumes the load input is already qualified by the enable.
module rxf_xpar_out
    import rxf_pkg::*;
#(
    parameter int unsigned NPINS = RXF_PINS,
    localparam int unsigned SW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             load_bit,
    input  logic             en,
    input  logic [SW-1:0]    sel,
    output logic [NPINS-1:0] pins,
    output logic             strobe
);
    logic      data_q;
    xs_state_t st_q;

    // Data latch: keeps its value until the next accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
        end else if (load) begin
            data_q <= load_bit;
        end
    end

    // Strobe sequencer: a new bit restarts the delay; ticks advance it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= XS_IDLE;
        end else if (load) begin
            st_q <= XS_WAIT;
        end else if (tick) begin
            unique case (st_q)
                XS_WAIT: st_q <= XS_HIGH;
                XS_HIGH: st_q <= XS_IDLE;
                default: st_q <= XS_IDLE;
            endcase
        end
    end

    // Pin routing: only the selected pin carries data; the others output 0.
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign pins[p] = en & (sel == SW'(p)) & data_q;
    end

    // The strobe is active high, and only in transparent mode.
    always_comb begin
        strobe = en & (st_q == XS_HIGH);
    end
endmodule

// File: rtl/rx_bitfifo_xparent.sv
// Top level: receive payload bit FIFO with transparent serial output.
// Bits enter the FIFO and the serial output only inside an unlocked frame.
// Assumes bit_valid, frame_sync, eom, cycle_start and host_clear are pulses.
module rx_bitfifo_xparent
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = RXF_DEPTH,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          bit_valid,
    input  logic          bit_data,
    input  logic          frame_sync,
    input  logic          eom,
    input  logic          cycle_start,
    input  logic          cfg_init_cycle,
    input  logic          cfg_init_frame,
    input  logic          cfg_lock_eom,
    input  logic          cfg_xpar_en,
    input  logic          cfg_pin_sel,
    input  logic          host_clear,
    input  logic          rd_en,
    output logic          rd_data,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          overflow,
    output logic          locked,
    output logic          xd_pin_a,
    output logic          xd_pin_b,
    output logic          xd_strobe
);
    logic       clear_any;
    logic       accept;
    logic [1:0] pins;

    rxf_frame_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_valid      (bit_valid),
        .frame_sync     (frame_sync),
        .eom            (eom),
        .cycle_start    (cycle_start),
        .cfg_init_cycle (cfg_init_cycle),
        .cfg_init_frame (cfg_init_frame),
        .cfg_lock_eom   (cfg_lock_eom),
        .host_clear     (host_clear),
        .clear_any      (clear_any),
        .accept         (accept),
        .locked         (locked)
    );

    rxf_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_any),
        .wr_en    (accept),
        .wr_bit   (bit_data),
        .rd_req   (rd_en),
        .rd_bit   (rd_data),
        .level    (level),
        .empty    (empty),
        .full     (full),
        .overflow (overflow)
    );

    rxf_xpar_out #(.NPINS(2)) u_xout (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .load     (accept & cfg_xpar_en),
        .load_bit (bit_data),
        .en       (cfg_xpar_en),
        .sel      (cfg_pin_sel),
        .pins     (pins),
        .strobe   (xd_strobe)
    );

    assign xd_pin_a = pins[0];
    assign xd_pin_b = pins[1];
endmodule

// File: rtl/rxf_chk.sv
// Port-level protocol checker for rx_bitfifo_xparent, attached by bind.
module rxf_chk #(
    parameter int unsigned LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_tick,
    input logic          frame_sync,
    input logic          eom,
    input logic          cycle_start,
    input logic          cfg_init_cycle,
    input logic          cfg_init_frame,
    input logic          cfg_lock_eom,
    input logic          host_clear,
    input logic          rd_en,
    input logic [LW-1:0] level,
    input logic          empty,
    input logic          full,
    input logic          overflow,
    input logic          locked,
    input logic          xd_pin_a,
    input logic          xd_pin_b,
    input logic          xd_strobe
);
    logic clr;
    assign clr = host_clear | (cycle_start & cfg_init_cycle) | (frame_sync & cfg_init_frame);

    AST_LOCK_ON_EOM: assert property (@(posedge clk) disable iff (!rst_n)
        (eom && cfg_lock_eom && !clr) |=> locked); // R3
    AST_NO_SPURIOUS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(eom && cfg_lock_eom)) |=> !locked); // R3
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr) |=> (level <= $past(level))); // R2
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((level == $past(level)) || (level == $past(level) + 1'b1)
                    || (level + 1'b1 == $past(level)))); // R9
    AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow); // R10
    AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!overflow && !full) |=> !overflow); // R10
    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xd_strobe) |-> $past(bit_tick)); // R4
    AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xd_pin_a, xd_pin_b})); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !overflow && !locked)); // R8
    AST_POP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty && !clr) |=> (level <= $past(level))); // R9
endmodule

bind rx_bitfifo_xparent rxf_chk #(.LW(LW)) u_chk (.*);

// File: tb/tb_rx_bitfifo_xparent.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// all compared every cycle against a behavioural model of the requirements.
module tb_rx_bitfifo_xparent;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, bit_valid = 0, bit_data = 0, frame_sync = 0, eom = 0, cycle_start = 0;
    logic cfg_init_cycle = 0, cfg_init_frame = 0, cfg_lock_eom = 0, cfg_xpar_en = 0, cfg_pin_sel = 0;
    logic host_clear = 0, rd_en = 0;
    logic rd_data, empty, full, overflow, locked, xd_pin_a, xd_pin_b, xd_strobe;
    logic [5:0] level;

    int checks = 0;
    int errors = 0;

    // Behavioural model state.
    bit m_q[$];
    bit m_inframe, m_locked, m_ovf, m_data;
    int m_st; // 0 idle, 1 waiting for tick, 2 strobe high

    always #5 clk = ~clk;

    rx_bitfifo_xparent dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge using the current inputs.
    function automatic void model_edge();
        bit clr, acc, rd;
        clr = host_clear | (cycle_start & cfg_init_cycle) | (frame_sync & cfg_init_frame);
        acc = bit_valid & m_inframe & ~m_locked & ~clr;
        rd  = rd_en && (m_q.size() > 0) && !clr;
        if (clr) begin
            m_q.delete();
            m_ovf = 0;
        end else begin
            if (rd) void'(m_q.pop_front());
            if (acc) begin
                if (m_q.size() < DEPTH) m_q.push_back(bit_data);
                else m_ovf = 1;
            end
        end
        if (clr) m_locked = 0;
        else if (eom && cfg_lock_eom) m_locked = 1;
        if (frame_sync) m_inframe = 1;
        else if (eom || cycle_start) m_inframe = 0;
        if (acc && cfg_xpar_en) begin
            m_data = bit_data;
            m_st = 1;
        end else if (bit_tick) begin
            m_st = (m_st == 1) ? 2 : 0;
        end
    endfunction

    // Compare every output against the model (R9, R10, R3, R5, R4).
    task automatic compare_all();
        int la, lb;
        la = (cfg_xpar_en && !cfg_pin_sel) ? m_data : 0;
        lb = (cfg_xpar_en &&  cfg_pin_sel) ? m_data : 0;
        chk("R9 level", level, m_q.size());
        chk("R9 empty", empty, m_q.size() == 0);
        chk("R9 full", full, m_q.size() == DEPTH);
        if (m_q.size() > 0) chk("R9 rd_data", rd_data, m_q[0]);
        chk("R10 overflow", overflow, m_ovf);
        chk("R3 locked", locked, m_locked);
        chk("R5 pin_a", xd_pin_a, la);
        chk("R5 pin_b", xd_pin_b, lb);
        chk("R4 strobe", xd_strobe, cfg_xpar_en && m_st == 2);
    endtask

    // One clock: edge, model update, then sample at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        {bit_tick, bit_valid, frame_sync, eom, cycle_start, host_clear, rd_en} = '0;
    endtask

    task automatic send_bit(input bit b);
        bit_valid = 1; bit_data = b; step();
    endtask

    task automatic pulse_sync(); frame_sync = 1; step(); endtask
    task automatic pulse_eom();  eom = 1; step(); endtask
    task automatic tick();       bit_tick = 1; step(); endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_inframe = 0; m_locked = 0; m_ovf = 0; m_data = 0; m_st = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 reset empty", empty, 1);
        chk("R3 reset locked", locked, 0);
        chk("R4 reset strobe", xd_strobe, 0);

        // R1: bits before frame sync are ignored.
        cfg_xpar_en = 1; cfg_pin_sel = 0;
        send_bit(1); send_bit(1);
        chk("R1 pre-sync level", level, 0);
        chk("R1 pre-sync pin", xd_pin_a, 0);

        // R9/R4/R11: payload after sync, strobe timing and data hold.
        pulse_sync();
        send_bit(1);
        chk("R5 pin_a carries bit", xd_pin_a, 1);
        chk("R4 strobe low before tick", xd_strobe, 0);
        tick();
        chk("R4 strobe high after first tick", xd_strobe, 1);
        step();
        chk("R4 strobe holds between ticks", xd_strobe, 1);
        tick();
        chk("R4 strobe low after second tick", xd_strobe, 0);
        repeat (5) step();
        chk("R11 pin holds", xd_pin_a, 1);
        send_bit(0); send_bit(1); send_bit(1);
        chk("R9 level after four", level, 4);
        chk("R9 oldest first", rd_data, 1);
        cfg_pin_sel = 1; step();
        chk("R5 pin_b selected", xd_pin_b, 1);
        chk("R5 pin_a idle", xd_pin_a, 0);

        // R3/R2: lock at end of message freezes both paths.
        cfg_lock_eom = 1;
        send_bit(0);
        pulse_eom();
        chk("R3 locked after eom", locked, 1);
        pulse_sync();
        send_bit(1); send_bit(1);
        chk("R2 locked level frozen", level, 5);
        chk("R2 locked pin frozen", xd_pin_b, 0);

        // R8: host clear empties and unlocks.
        host_clear = 1; step();
        chk("R8 clear level", level, 0);
        chk("R8 clear unlock", locked, 0);

        // R3: option off never locks.
        cfg_lock_eom = 0;
        pulse_sync(); send_bit(1); pulse_eom();
        chk("R3 no lock when disabled", locked, 0);

        // R7: init at frame start.
        pulse_sync(); send_bit(0); send_bit(1);
        cfg_init_frame = 0; pulse_sync();
        chk("R7 keep without option", level, 3);
        cfg_init_frame = 1; pulse_sync();
        chk("R7 init at frame sync", level, 0);
        cfg_init_frame = 0;

        // R6: init at cycle start.
        send_bit(1); send_bit(0);
        cfg_init_cycle = 1; cycle_start = 1; step();
        chk("R6 init at cycle start", level, 0);
        cfg_init_cycle = 0;

        // R10: overflow when full.
        pulse_sync();
        for (int i = 0; i < DEPTH + 2; i++) send_bit(i[0]);
        chk("R10 full", full, 1);
        chk("R10 overflow set", overflow, 1);
        chk("R10 transparent still updates", xd_pin_b, 1);
        repeat (3) step();
        chk("R10 overflow sticky", overflow, 1);
        host_clear = 1; step();
        chk("R8 overflow cleared", overflow, 0);

        // Random traffic, checked every cycle against the model.
        for (int n = 0; n < 6000; n++) begin
            bit_tick    = ($urandom % 4) == 0;
            bit_valid   = ($urandom % 3) == 0;
            bit_data    = $urandom;
            frame_sync  = ($urandom % 60) == 0;
            eom         = ($urandom % 80) == 0;
            cycle_start = ($urandom % 150) == 0;
            host_clear  = ($urandom % 300) == 0;
            rd_en       = ($urandom % 5) == 0;
            if (n % 500 == 0) begin
                cfg_init_cycle = $urandom; cfg_init_frame = $urandom;
                cfg_lock_eom = $urandom; cfg_xpar_en = $urandom; cfg_pin_sel = $urandom;
            end
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule